// File: doc/BRIEF.md
# Compare Timer with Table-Fed Reload

This block is a single-channel timer whose compare value is refilled, one period at a time, from a circular table held in an outside memory. A counter runs up from zero to a programmable reload value, or down from that value to zero. Its wrap is the update event. One compare channel watches the counter. On an equal value it inverts a square-wave output and raises a compare event. That event, and the update event if it is enabled, asks for the next table word over a simple request/acknowledge port. The word that comes back becomes the compare value for the following period.

A compare value above the reload value can never match. In that case the compare event is still raised, on the counter wrap, and the output holds its level. A table-driven waveform therefore keeps stepping through its table once per period, even across periods in which the output stays steady. Status flags record events regardless of any enable. They are cleared by writing ones. The interrupt line combines each flag with its own enable bit.

Top module: `cmp_dma_timer`

## Requirements
- R1: In up mode the counter steps 0,1,…,reload and returns to 0. The update event is the cycle in which the counter holds the reload value (or more), and `flag_upd` reads 1 from the next cycle.
- R2: In down mode (`count_down`=1) the counter steps reload,…,1,0 and is loaded with reload after 0. The update event is the cycle in which the counter holds 0, and it starts from 0 after enable.
- R3: If the active compare value is not above reload, then in the cycle where the counter equals it `wave_out` inverts and `flag_cmp` is set. Both are visible one cycle later.
- R4: If the active compare value is above reload, `wave_out` never changes while enabled, and `flag_cmp` is set on every update event.
- R5: A compare event while `dma_en_cmp`=1, or an update event while `dma_en_upd`=1, raises `dma_req` one cycle later. `dma_req` stays high until a cycle with `dma_ack`=1.
- R6: `dma_addr` = `tbl_base` + index. An accepted acknowledge (`dma_ack` while `dma_req`) stores `dma_data` as the pending compare value and advances the index, which returns to 0 after `tbl_last`. The pending value becomes active at the next update event. A word acknowledged in the cycle of an update event is active for the period that starts.
- R7: A request-raising event in a cycle where `dma_req` is already high and `dma_ack` is low sets `flag_ovr`. The request stays single.
- R8: Flags are set by their events whatever the enables are. `irq` = (`flag_upd` & `irq_en_upd`) | (`flag_cmp` & `irq_en_cmp`), with no added delay.
- R9: `flag_clr` bit 0 clears `flag_upd`, bit 1 clears `flag_cmp` and bit 2 clears `flag_ovr`. A set in the same cycle wins over a clear.
- R10: While `tmr_en`=0, from the next cycle on, the counter is 0, `wave_out` equals `idle_level`, the index is 0 and `dma_req` is 0. Reset gives `wave_out`=0, all flags 0, `dma_req`=0 and an active compare of all ones.
- R11: `cmp_load` writes `cmp_value` into both the active and pending compare values at once. It wins over an acknowledge or update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Timer run enable |
| count_down | input | 1 | 1 = count down, 0 = count up |
| reload_val | input | CW | Period end value |
| cmp_load | input | 1 | Direct compare write strobe |
| cmp_value | input | CW | Direct compare write data |
| idle_level | input | 1 | Output level while disabled |
| dma_en_upd | input | 1 | Update event raises a table request |
| dma_en_cmp | input | 1 | Compare event raises a table request |
| irq_en_upd | input | 1 | Interrupt enable for update flag |
| irq_en_cmp | input | 1 | Interrupt enable for compare flag |
| flag_clr | input | 3 | Write-one-to-clear strobes {ovr, cmp, upd} |
| tbl_base | input | AW | Table start address |
| tbl_last | input | AW | Last table index (length minus one) |
| dma_req | output | 1 | Table word request |
| dma_addr | output | AW | Address of requested word |
| dma_ack | input | 1 | Word delivered this cycle |
| dma_data | input | CW | Delivered table word |
| wave_out | output | 1 | Toggling output |
| flag_upd | output | 1 | Update event flag |
| flag_cmp | output | 1 | Compare event flag |
| flag_ovr | output | 1 | Request overrun flag |
| irq | output | 1 | Interrupt line |

## Verification
Two collisions matter. An acknowledge can land in the cycle of an update event. A new request-raising event can also come while an earlier request is still open. The bench sets the responder latency against the period: short latencies with small periods push acknowledges onto wrap cycles, and a latency longer than a period forces overruns. A per-cycle reference built from the requirements judges which compare value governs each period and when `flag_ovr` rises. Periodic flag clears are placed so that some land on event cycles, which exercises set-over-clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Next counter value for either direction.
  function automatic logic [15:0] cnt_step(input logic [15:0] c,
                                           input logic [15:0] rld,
                                           input logic down);
    if (down) return (c == '0) ? rld : c - 16'd1;
    else      return (c >= rld) ? '0 : c + 16'd1;
  endfunction

  // Counter sits on its period boundary.
  function automatic logic at_wrap(input logic [15:0] c,
                                   input logic [15:0] rld,
                                   input logic down);
    return down ? (c == '0) : (c >= rld);
  endfunction

  // Compare value lies outside the counting range.
  function automatic logic out_of_range(input logic [15:0] cv,
                                        input logic [15:0] rld);
    return cv > rld;
  endfunction

  // Circular table index.
  function automatic logic [7:0] idx_step(input logic [7:0] i,
                                          input logic [7:0] last);
    return (i >= last) ? '0 : i + 8'd1;
  endfunction

endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          down,
  input  logic [CW-1:0] rld,
  output logic [CW-1:0] cnt,
  output logic          upd_evt
);
  import cdt_pkg::*;

  logic [15:0] cnt_w, rld_w, nxt_w;
  assign cnt_w   = 16'(cnt);
  assign rld_w   = 16'(rld);
  assign nxt_w   = cnt_step(cnt_w, rld_w, down);
  assign upd_evt = en && at_wrap(cnt_w, rld_w, down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= CW'(nxt_w);
  end

  AST_UP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && upd_evt) |=> (cnt == '0));                        // R1
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && upd_evt) |=> (cnt == $past(rld)));                 // R2

endmodule

// File: rtl/cdt_compare.sv
module cdt_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] rld,
  input  logic          upd_evt,
  input  logic          cmp_load,
  input  logic [CW-1:0] cmp_value,
  input  logic          word_take,
  input  logic [CW-1:0] word_data,
  input  logic          idle_level,
  output logic          cmp_evt,
  output logic          cmp_match,
  output logic          wave
);
  import cdt_pkg::*;

  logic [CW-1:0] ccr_act, ccr_pend;
  logic          beyond;

  assign beyond    = out_of_range(16'(ccr_act), 16'(rld));
  assign cmp_match = en && !beyond && (cnt == ccr_act);
  assign cmp_evt   = cmp_match || (beyond && upd_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_act  <= '1;
      ccr_pend <= '1;
    end else if (cmp_load) begin
      ccr_act  <= cmp_value;
      ccr_pend <= cmp_value;
    end else begin
      if (word_take) ccr_pend <= word_data;
      if (upd_evt)   ccr_act  <= word_take ? word_data : ccr_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wave <= 1'b0;
    else if (!en)       wave <= idle_level;
    else if (cmp_match) wave <= ~wave;
  end

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |=> (wave != $past(wave)));                             // R3
  AST_HOLD_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && beyond) |=> $stable(wave));                                // R4
  AST_BEYOND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (beyond && upd_evt) |-> cmp_evt);                                 // R4

endmodule

// File: rtl/cdt_fetch.sv
module cdt_fetch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trig,
  input  logic          ack,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          take,
  output logic          ovr_evt
);
  import cdt_pkg::*;

  logic [AW-1:0] idx;

  assign take    = en && req && ack;
  assign ovr_evt = trig && req && !ack;
  assign addr    = base + idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      idx <= '0;
    end else if (!en) begin
      req <= 1'b0;
      idx <= '0;
    end else begin
      if (trig)      req <= 1'b1;
      else if (take) req <= 1'b0;
      if (take)      idx <= AW'(idx_step(8'(idx), 8'(last)));
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req && !ack) |=> req);                                     // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx >= last) |=> (addr == base));                        // R6

endmodule

// File: rtl/cmp_dma_timer.sv
module cmp_dma_timer #(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_en,
  input  logic          count_down,
  input  logic [CW-1:0] reload_val,
  input  logic          cmp_load,
  input  logic [CW-1:0] cmp_value,
  input  logic          idle_level,
  input  logic          dma_en_upd,
  input  logic          dma_en_cmp,
  input  logic          irq_en_upd,
  input  logic          irq_en_cmp,
  input  logic [2:0]    flag_clr,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_last,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  input  logic          dma_ack,
  input  logic [CW-1:0] dma_data,
  output logic          wave_out,
  output logic          flag_upd,
  output logic          flag_cmp,
  output logic          flag_ovr,
  output logic          irq
);
  logic [CW-1:0] cnt;
  logic upd_evt, cmp_evt, cmp_match, trig, take, ovr_evt;

  cdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .down(count_down),
    .rld(reload_val), .cnt(cnt), .upd_evt(upd_evt));

  cdt_compare #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .cnt(cnt), .rld(reload_val),
    .upd_evt(upd_evt), .cmp_load(cmp_load), .cmp_value(cmp_value),
    .word_take(take), .word_data(dma_data), .idle_level(idle_level),
    .cmp_evt(cmp_evt), .cmp_match(cmp_match), .wave(wave_out));

  assign trig = (cmp_evt && dma_en_cmp) || (upd_evt && dma_en_upd);

  cdt_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .trig(trig), .ack(dma_ack),
    .base(tbl_base), .last(tbl_last), .req(dma_req), .addr(dma_addr),
    .take(take), .ovr_evt(ovr_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_upd <= 1'b0;
      flag_cmp <= 1'b0;
      flag_ovr <= 1'b0;
    end else begin
      flag_upd <= upd_evt | (flag_upd & ~flag_clr[0]);
      flag_cmp <= cmp_evt | (flag_cmp & ~flag_clr[1]);
      flag_ovr <= ovr_evt | (flag_ovr & ~flag_clr[2]);
    end
  end

  assign irq = (flag_upd & irq_en_upd) | (flag_cmp & irq_en_cmp);

  AST_UPD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> flag_upd);                                            // R8
  AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |=> flag_cmp);                                          // R3
  AST_NO_OVERRUN_UNSEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && dma_req && !dma_ack) |=> flag_ovr);                      // R7
  AST_REQ_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> dma_req);                                                // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (!dma_req && wave_out == $past(idle_level)));         // R10

endmodule

// File: tb/cmp_dma_timer_tb_top.sv
module cmp_dma_timer_tb_top;
  localparam int CW = 16;
  localparam int AW = 8;
  localparam int NV = 5;
  localparam int V_RLD [NV] = '{7, 9, 5, 3, 6};
  localparam int V_DOWN[NV] = '{0, 1, 0, 0, 1};
  localparam int V_CCR [NV] = '{3, 65535, 20, 1, 2};
  localparam int V_DCMP[NV] = '{1, 0, 1, 1, 0};
  localparam int V_DUPD[NV] = '{0, 0, 0, 0, 1};
  localparam int V_LAT [NV] = '{1, 1, 2, 6, 3};
  localparam int V_BASE[NV] = '{0, 2, 4, 1, 3};
  localparam int V_LAST[NV] = '{7, 3, 5, 2, 4};
  localparam int V_CYC [NV] = '{60, 50, 70, 40, 60};

  logic clk = 0, rst_n = 0;
  logic en = 0, down = 0, cload = 0, idle = 0;
  logic de_u = 0, de_c = 0, ie_u = 0, ie_c = 0;
  logic [2:0] clr = 0;
  logic [CW-1:0] rld = 7, cval = 0, ddata = 0;
  logic [AW-1:0] base = 0, last = 0;
  logic dack = 0;
  logic dreq, wave, fu, fc, fo, irq;
  logic [AW-1:0] daddr;

  int n_tests = 0, n_fail = 0, cyc = 0, lat = 1, wcnt = 0;
  logic [15:0] mem [0:15];

  always #10 clk = ~clk;

  cmp_dma_timer #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_en(en), .count_down(down),
    .reload_val(rld), .cmp_load(cload), .cmp_value(cval), .idle_level(idle),
    .dma_en_upd(de_u), .dma_en_cmp(de_c), .irq_en_upd(ie_u), .irq_en_cmp(ie_c),
    .flag_clr(clr), .tbl_base(base), .tbl_last(last), .dma_req(dreq),
    .dma_addr(daddr), .dma_ack(dack), .dma_data(ddata), .wave_out(wave),
    .flag_upd(fu), .flag_cmp(fc), .flag_ovr(fo), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference state written from the requirements.
  logic [15:0] m_c, m_act, m_pend;
  logic [7:0]  m_idx;
  logic m_req, m_tog, m_fu, m_fc, m_fo;
  bit w_wrap, w_far, w_hit, w_cev, w_trig, w_take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c <= 0; m_act <= 16'hFFFF; m_pend <= 16'hFFFF; m_idx <= 0;
      m_req <= 0; m_tog <= 0; m_fu <= 0; m_fc <= 0; m_fo <= 0;
    end else begin
      w_wrap = en && (down ? (m_c == 0) : (m_c >= rld));        // R1 R2
      w_far  = m_act > rld;
      w_hit  = en && !w_far && (m_c == m_act);                  // R3
      w_cev  = w_hit || (w_far && w_wrap);                      // R4
      w_trig = (w_cev && de_c) || (w_wrap && de_u);             // R5
      w_take = en && m_req && dack;                             // R6
      if (!en) m_c <= 0;
      else if (down) m_c <= (m_c == 0) ? rld : m_c - 1;
      else m_c <= (m_c >= rld) ? 16'd0 : m_c + 1;
      m_tog <= !en ? idle : (w_hit ? !m_tog : m_tog);           // R10
      if (cload) begin m_act <= cval; m_pend <= cval; end       // R11
      else begin
        if (w_take) m_pend <= ddata;
        if (w_wrap) m_act <= w_take ? ddata : m_pend;
      end
      m_req <= !en ? 1'b0 : (w_trig ? 1'b1 : (w_take ? 1'b0 : m_req));
      m_idx <= !en ? 8'd0 : (w_take ? ((m_idx >= last) ? 8'd0 : m_idx + 1) : m_idx);
      m_fu <= w_wrap || (m_fu && !clr[0]);                      // R9
      m_fc <= w_cev  || (m_fc && !clr[1]);
      m_fo <= (w_trig && m_req && !dack) || (m_fo && !clr[2]);  // R7
    end
  end

  // Table responder.
  always @(negedge clk) begin
    if (dack) dack <= 0;
    else if (dreq) begin
      wcnt <= wcnt + 1;
      if (wcnt + 1 >= lat) begin
        dack <= 1; ddata <= mem[daddr[3:0]]; wcnt <= 0;
      end
    end else wcnt <= 0;
  end

  // Per-cycle comparison against the reference.
  bit chk_on = 0;
  int mism = 0, tog_edges = 0, cmp_sets = 0, ovr_seen = 0;
  logic [31:0] f_act, f_exp, e_vec, a_vec;
  logic prev_wave = 0;
  always @(negedge clk) begin
    if (chk_on) begin
      e_vec = {19'd0, m_tog, m_fu, m_fc, m_fo,
               (m_fu & ie_u) | (m_fc & ie_c), m_req, base + m_idx[AW-1:0]};
      a_vec = {19'd0, wave, fu, fc, fo, irq, dreq, daddr};
      if (a_vec != e_vec) begin
        if (mism == 0) begin f_act = a_vec; f_exp = e_vec; end
        mism++;
      end
      if (wave != prev_wave) tog_edges++;
      if (fc) cmp_sets++;
      if (fo) ovr_seen++;
    end
    prev_wave <= wave;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++)
      mem[i] = (i % 4 == 3) ? 16'hFFFF : 16'((i * 3 + 1) & 7);

    tick(3);
    // Reset state (R10)
    check(wave == 0 && fu == 0 && fc == 0 && fo == 0, "R10 reset outputs",
          {wave, fu, fc, fo}, 0);
    check(dreq == 0 && irq == 0, "R10 reset request/irq", {dreq, irq}, 0);
    rst_n = 1;
    tick(2);

    for (int v = 0; v < NV; v++) begin
      en = 0; rld = CW'(V_RLD[v]); down = V_DOWN[v]; de_c = V_DCMP[v];
      de_u = V_DUPD[v]; lat = V_LAT[v]; base = AW'(V_BASE[v]);
      last = AW'(V_LAST[v]); ie_u = v[0]; ie_c = 1; idle = v[1];
      tick(1);
      cval = CW'(V_CCR[v]); cload = 1; clr = 3'b111;
      tick(1);
      cload = 0; clr = 0;
      tick(1);
      mism = 0; tog_edges = 0; cmp_sets = 0; ovr_seen = 0; chk_on = 1;
      en = 1;
      for (int k = 0; k < V_CYC[v]; k++) begin
        clr = (k % 7 == 6) ? 3'b111 : 3'b000;
        tick(1);
      end
      clr = 0;
      en = 0;
      tick(2);
      chk_on = 0;
      check(mism == 0, $sformatf("R1 R2 R3 R5 R6 R8 R9 vector %0d", v), f_act, f_exp);
      if (v == 0) check(tog_edges > 4, "R3 output toggles", tog_edges, 5);
      if (v == 1) begin
        check(tog_edges == 0, "R4 output steady beyond reload", tog_edges, 0);
        check(cmp_sets > 0, "R4 compare flag on wrap", cmp_sets, 1);
      end
      if (v == 3) check(ovr_seen > 0, "R7 overrun flagged", ovr_seen, 1);
      if (v == 4) check(wave == idle, "R10 idle level after disable", wave, idle);
    end

    // Disabled: index back to base, no request (R10)
    check(daddr == base && dreq == 0, "R10 index reset", {dreq, daddr}, {1'b0, base});

    // Write-one-to-clear (R9) and irq gating (R8)
    clr = 3'b111; tick(1); clr = 0; tick(1);
    check({fu, fc, fo} == 0, "R9 flags cleared", {fu, fc, fo}, 0);
    rld = 4; down = 0; de_c = 0; de_u = 0; ie_u = 0; ie_c = 0;
    cval = 16'hFFFF; cload = 1; tick(1); cload = 0;
    en = 1; tick(6); en = 0; tick(1);
    check(fu == 1 && irq == 0, "R8 flag set with irq disabled", {fu, irq}, 2'b10);
    ie_u = 1; #1;
    check(irq == 1, "R8 irq follows enable", irq, 1);
    ie_u = 0;

    // Direct compare load takes effect at once (R11)
    clr = 3'b111; idle = 0; rld = 7; tick(1); clr = 0;
    cval = 2; cload = 1; tick(1); cload = 0;
    check(wave == 0, "R11 idle before enable", wave, 0);
    en = 1; tick(2);
    check(wave == 0, "R11 no toggle before match", wave, 0);
    tick(1);
    check(wave == 1, "R11 R3 toggle at loaded compare", wave, 1);
    en = 0; tick(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule